// File: doc/BRIEF.md
# Serial Bus Word Timing Tracker

This block sits in a peripheral chip on a bit-serial instruction bus that runs from a two-phase clock. Each bus word lasts a fixed number of bit times. A single SYNC line marks the instruction field of every instruction word. The tracker turns the phase strobes into bit times and accepts SYNC only when it is stable over a whole phase-2 strobe. It runs a bit-time index that SYNC re-aligns. It also reports whether the current word is an instruction, or the operand word that follows a two-word opcode. On operand words the bus sends no SYNC, and the index coasts through them on its own count.

No reset wire reaches the peripheral. The block resets itself when SYNC stays high for longer than one instruction field. That reset clears the index and the word flags. It also forces a local ROM bank-select bit to bank 0. The reset holds for as long as SYNC stays high and releases on the first bit time with SYNC low. The `rst` port is only the fabric's power-on reset and is not part of the bus protocol.

Top module: `sbus_word_timer`

## Requirements
- R1: A bit time is one phi1 strobe followed by the end of a phi2 strobe. `bit_idx` steps by one in the clock after phi2 falls. It wraps from 55 to 0, and at that wrap `word_start` pulses for one clock.
- R2: A bit time with qualified SYNC high, after one with SYNC low, is a SYNC rise. On a rise `bit_idx` goes to 0, `word_start` pulses and `instr_valid` goes high, whatever value the index held before.
- R3: SYNC counts as high for a bit time only if it is high in every clock of the phi2 strobe. SYNC that is low in the first phi2 clock and rises later counts as low.
- R4: A phi2 strobe with no phi1 strobe since the last bit time is not a bit time, and `bit_idx` does not change.
- R5: If a word opens with no SYNC rise, `instr_valid` goes low for that word. `operand_word` goes high for that word only if `two_word` was asserted during the instruction word before it; otherwise `operand_word` is low.
- R6: Ten consecutive bit times with SYNC high do not raise `chip_rst`. The eleventh consecutive high bit time sets `chip_rst`.
- R7: While `chip_rst` is high, `bit_idx` is 0 and `instr_valid` and `operand_word` are 0. `chip_rst` stays high through further high bit times and falls on the first bit time with SYNC low. `bit_idx` is still 0 after that bit time and then counts on from 0.
- R8: A one-clock `bank_wr` loads `bank_din` into `bank`. When `chip_rst` sets, `bank` goes to 0, and `bank_wr` has no effect while `chip_rst` is high.
- R9: With `rst` high, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; phase strobes are sampled on it |
| rst | input | 1 | Synchronous active-high power-on reset |
| phi1 | input | 1 | Phase-1 strobe, level, one or more clocks wide |
| phi2 | input | 1 | Phase-2 strobe, level, one or more clocks wide |
| sync | input | 1 | Bus SYNC line |
| two_word | input | 1 | From core: the current instruction takes a second word |
| bank_wr | input | 1 | From core: load the bank-select bit |
| bank_din | input | 1 | Bank value to load |
| bit_idx | output | 6 | Bit-time index within the word, 0 to 55 |
| word_start | output | 1 | One-clock pulse when the index becomes 0 |
| instr_valid | output | 1 | Current word is an instruction word |
| operand_word | output | 1 | Current word is the second word of a two-word instruction |
| chip_rst | output | 1 | Reset inferred from an overlong SYNC |
| bank | output | 1 | ROM bank-select bit |

## Verification
The bench drives SYNC lengths of exactly ten and exactly eleven bit times. A detector off by one in either direction would either miss the reset or fire on a normal instruction. It sends a SYNC that rises partway through phi2, which a design that samples SYNC only at the end of the strobe would take as a real SYNC. It also sends a lone phi2 with no phi1, which a design without phase pairing would count as a bit time. It raises SYNC at bit 20 of a coasting word to show the index snaps to 0 rather than keep its own count. It tries a bank write during the inferred reset, where a wrong priority would leave a nonzero bank.

// File: rtl/swt_pkg.sv
package swt_pkg;
  // One completed bit time and the qualified SYNC level seen during it.
  typedef struct packed {
    logic tick;
    logic sbit;
  } bit_evt_t;
endpackage

// File: rtl/swt_bit_qual.sv
module swt_bit_qual
  import swt_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     phi1,
  input  logic     phi2,
  input  logic     sync,
  output bit_evt_t evt
);
  logic p2_d;
  logic acc;
  logic armed;

  // A bit time closes on the falling edge of phi2 if phi1 came first.
  assign evt.tick = p2_d & ~phi2 & armed;
  assign evt.sbit = acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      p2_d  <= 1'b0;
      acc   <= 1'b0;
      armed <= 1'b0;
    end else begin
      p2_d <= phi2;
      // SYNC must hold across every clock of the phi2 strobe.
      if (phi2 && !p2_d)
        acc <= sync;
      else if (phi2)
        acc <= acc & sync;
      if (phi1)
        armed <= 1'b1;
      else if (evt.tick)
        armed <= 1'b0;
    end
  end
endmodule

// File: rtl/swt_long_sync.sv
module swt_long_sync
  import swt_pkg::*;
#(
  parameter int SYNC_BITS = 10
) (
  input  logic     clk,
  input  logic     rst,
  input  bit_evt_t evt,
  output logic     rst_now,
  output logic     chip_rst
);
  localparam int HI_MAX = SYNC_BITS + 1;
  localparam int HI_W   = $clog2(HI_MAX + 1);

  logic [HI_W-1:0] hi_cnt;
  logic [HI_W-1:0] hi_nxt;

  // Saturating run length of high SYNC bit times.
  always_comb begin
    if (!evt.sbit)
      hi_nxt = '0;
    else if (hi_cnt == HI_W'(HI_MAX))
      hi_nxt = hi_cnt;
    else
      hi_nxt = hi_cnt + 1'b1;
  end

  assign rst_now = evt.tick & evt.sbit & (hi_nxt == HI_W'(HI_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt   <= '0;
      chip_rst <= 1'b0;
    end else if (evt.tick) begin
      hi_cnt   <= hi_nxt;
      chip_rst <= rst_now;
    end
  end
endmodule

// File: rtl/swt_word_ctr.sv
module swt_word_ctr
  import swt_pkg::*;
#(
  parameter int WORD_BITS = 56,
  parameter int IDX_W     = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  bit_evt_t         evt,
  input  logic             clear,
  input  logic             two_word,
  output logic [IDX_W-1:0] bit_idx,
  output logic             word_start,
  output logic             instr_valid,
  output logic             operand_word
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_BITS - 1);

  logic sbit_d;
  logic pending;
  logic rise;
  logic pend_nxt;

  assign rise     = evt.sbit & ~sbit_d;
  assign pend_nxt = pending | (two_word & instr_valid);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_idx      <= '0;
      word_start   <= 1'b0;
      instr_valid  <= 1'b0;
      operand_word <= 1'b0;
      pending      <= 1'b0;
      sbit_d       <= 1'b0;
    end else begin
      word_start <= 1'b0;
      if (!evt.tick) begin
        pending <= pend_nxt;
      end else begin
        sbit_d <= evt.sbit;
        if (clear) begin
          bit_idx      <= '0;
          instr_valid  <= 1'b0;
          operand_word <= 1'b0;
          pending      <= 1'b0;
        end else if (rise) begin
          // SYNC is authoritative: realign wherever the count stood.
          bit_idx      <= '0;
          word_start   <= 1'b1;
          instr_valid  <= 1'b1;
          operand_word <= 1'b0;
          pending      <= 1'b0;
        end else if (bit_idx == LAST) begin
          // Word boundary without SYNC: coast into an operand word.
          bit_idx      <= '0;
          word_start   <= 1'b1;
          instr_valid  <= 1'b0;
          operand_word <= pend_nxt;
          pending      <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 1'b1;
          pending <= pend_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/sbus_word_timer.sv
module sbus_word_timer
  import swt_pkg::*;
#(
  parameter int WORD_BITS = 56,
  parameter int SYNC_BITS = 10,
  parameter int IDX_W     = $clog2(WORD_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             phi1,
  input  logic             phi2,
  input  logic             sync,
  input  logic             two_word,
  input  logic             bank_wr,
  input  logic             bank_din,
  output logic [IDX_W-1:0] bit_idx,
  output logic             word_start,
  output logic             instr_valid,
  output logic             operand_word,
  output logic             chip_rst,
  output logic             bank
);
  bit_evt_t evt;
  logic     rst_now;
  logic     clear;

  swt_bit_qual u_qual (
    .clk  (clk),
    .rst  (rst),
    .phi1 (phi1),
    .phi2 (phi2),
    .sync (sync),
    .evt  (evt)
  );

  swt_long_sync #(.SYNC_BITS(SYNC_BITS)) u_long (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .rst_now  (rst_now),
    .chip_rst (chip_rst)
  );

  assign clear = rst_now | chip_rst;

  swt_word_ctr #(.WORD_BITS(WORD_BITS), .IDX_W(IDX_W)) u_ctr (
    .clk          (clk),
    .rst          (rst),
    .evt          (evt),
    .clear        (clear),
    .two_word     (two_word),
    .bit_idx      (bit_idx),
    .word_start   (word_start),
    .instr_valid  (instr_valid),
    .operand_word (operand_word)
  );

  // Bank select: inferred reset wins over a core write.
  always_ff @(posedge clk) begin
    if (rst || clear)
      bank <= 1'b0;
    else if (bank_wr)
      bank <= bank_din;
  end
endmodule

// File: rtl/swt_checker.sv
module swt_checker #(
  parameter int WORD_BITS = 56,
  parameter int IDX_W     = $clog2(WORD_BITS)
) (
  input logic             clk,
  input logic             rst,
  input logic             phi2,
  input logic             bank_wr,
  input logic [IDX_W-1:0] bit_idx,
  input logic             word_start,
  input logic             instr_valid,
  input logic             operand_word,
  input logic             chip_rst,
  input logic             bank
);
  assert_idx_range_R1: assert property (@(posedge clk) disable iff (rst)
    bit_idx < IDX_W'(WORD_BITS));

  assert_start_at_zero_R1: assert property (@(posedge clk) disable iff (rst)
    word_start |-> bit_idx == '0);

  assert_step_on_phi2_end_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_idx != $past(bit_idx)) |-> (!$past(phi2) && $past(phi2, 2)));

  assert_operand_not_instr_R5: assert property (@(posedge clk) disable iff (rst)
    operand_word |-> !instr_valid);

  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
    chip_rst |-> (bit_idx == '0 && !instr_valid && !operand_word && !word_start));

  assert_bank_change_R8: assert property (@(posedge clk) disable iff (rst)
    (bank != $past(bank)) |-> ($past(bank_wr) || chip_rst));

  assert_bank_zero_in_reset_R8: assert property (@(posedge clk) disable iff (rst)
    chip_rst |-> !bank);
endmodule

bind sbus_word_timer swt_checker #(.WORD_BITS(WORD_BITS), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .phi2         (phi2),
  .bank_wr      (bank_wr),
  .bit_idx      (bit_idx),
  .word_start   (word_start),
  .instr_valid  (instr_valid),
  .operand_word (operand_word),
  .chip_rst     (chip_rst),
  .bank         (bank)
);

// File: tb/tb_sbus_word_timer.sv
module tb_sbus_word_timer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phi1 = 1'b0, phi2 = 1'b0, sync = 1'b0;
  logic       two_word = 1'b0, bank_wr = 1'b0, bank_din = 1'b0;
  logic [5:0] bit_idx;
  logic       word_start, instr_valid, operand_word, chip_rst, bank;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sbus_word_timer dut (
    .clk(clk), .rst(rst), .phi1(phi1), .phi2(phi2), .sync(sync),
    .two_word(two_word), .bank_wr(bank_wr), .bank_din(bank_din),
    .bit_idx(bit_idx), .word_start(word_start), .instr_valid(instr_valid),
    .operand_word(operand_word), .chip_rst(chip_rst), .bank(bank)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One bit time; returns at the falling edge after outputs have updated.
  task automatic bit_t(input logic s, input bit late = 1'b0, input bit no_p1 = 1'b0);
    @(negedge clk); phi1 = !no_p1;
    @(negedge clk); phi1 = 1'b0;
    @(negedge clk); phi2 = 1'b1; sync = late ? 1'b0 : s;
    @(negedge clk); if (late) sync = s;
    @(negedge clk); phi2 = 1'b0;
    @(negedge clk);
  endtask

  task automatic bits(input logic s, input int n);
    for (int i = 0; i < n; i++) bit_t(s);
  endtask

  task automatic t_reset();
    chk("R9", "bit_idx", bit_idx, 0);
    chk("R9", "flags", {word_start, instr_valid, operand_word, chip_rst, bank}, 0);
  endtask

  task automatic t_coast_and_phase();
    bits(1'b0, 3);
    chk("R1", "bit_idx after 3 bits", bit_idx, 3);
    bit_t(1'b0, 1'b0, 1'b1);
    chk("R4", "bit_idx after lone phi2", bit_idx, 3);
    bit_t(1'b1, 1'b1);
    chk("R3", "bit_idx after late SYNC", bit_idx, 4);
    chk("R3", "instr_valid after late SYNC", instr_valid, 0);
    bit_t(1'b0);
    chk("R3", "bit_idx after low bit", bit_idx, 5);
  endtask

  task automatic t_two_word();
    bit_t(1'b1);
    chk("R2", "bit_idx on rise", bit_idx, 0);
    chk("R2", "word_start on rise", word_start, 1);
    chk("R2", "instr_valid on rise", instr_valid, 1);
    two_word = 1'b1;
    bit_t(1'b1);
    two_word = 1'b0;
    bits(1'b1, 8);
    chk("R6", "chip_rst after 10 high", chip_rst, 0);
    chk("R6", "bit_idx after 10 high", bit_idx, 9);
    bits(1'b0, 46);
    chk("R1", "bit_idx at word end", bit_idx, 55);
    bit_t(1'b0);
    chk("R1", "bit_idx wrap", bit_idx, 0);
    chk("R1", "word_start on wrap", word_start, 1);
    chk("R5", "instr_valid on operand word", instr_valid, 0);
    chk("R5", "operand_word after two-word", operand_word, 1);
    bits(1'b0, 55);
    chk("R5", "operand_word held", operand_word, 1);
    bit_t(1'b1);
    chk("R5", "operand_word cleared by SYNC", operand_word, 0);
    chk("R2", "instr_valid after SYNC", instr_valid, 1);
    bits(1'b1, 9);
    bits(1'b0, 47);
    chk("R5", "operand_word without two-word", operand_word, 0);
    chk("R5", "instr_valid without SYNC", instr_valid, 0);
  endtask

  task automatic t_resync();
    bits(1'b0, 20);
    chk("R1", "bit_idx coasting", bit_idx, 20);
    bit_t(1'b1);
    chk("R2", "bit_idx resync from 20", bit_idx, 0);
    chk("R2", "word_start on resync", word_start, 1);
    bit_t(1'b0);
  endtask

  task automatic t_long_sync();
    @(negedge clk); bank_wr = 1'b1; bank_din = 1'b1;
    @(negedge clk); bank_wr = 1'b0;
    chk("R8", "bank after write", bank, 1);
    bits(1'b1, 10);
    chk("R6", "chip_rst at 10 high", chip_rst, 0);
    chk("R8", "bank before reset", bank, 1);
    bit_t(1'b1);
    chk("R6", "chip_rst at 11 high", chip_rst, 1);
    chk("R7", "bit_idx in reset", bit_idx, 0);
    chk("R7", "instr_valid in reset", instr_valid, 0);
    chk("R8", "bank forced in reset", bank, 0);
    @(negedge clk); bank_wr = 1'b1; bank_din = 1'b1;
    @(negedge clk); bank_wr = 1'b0;
    chk("R8", "bank write ignored in reset", bank, 0);
    bit_t(1'b1);
    chk("R7", "chip_rst held while high", chip_rst, 1);
    bit_t(1'b0);
    chk("R7", "chip_rst released", chip_rst, 0);
    chk("R7", "bit_idx on release", bit_idx, 0);
    bit_t(1'b0);
    chk("R7", "bit_idx counts after release", bit_idx, 1);
    @(negedge clk); bank_wr = 1'b1; bank_din = 1'b1;
    @(negedge clk); bank_wr = 1'b0;
    chk("R8", "bank write after release", bank, 1);
  endtask

  task automatic t_power_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R9", "bank under rst", bank, 0);
    chk("R9", "bit_idx under rst", bit_idx, 0);
    rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_coast_and_phase();
    t_two_word();
    t_resync();
    t_long_sync();
    t_power_reset();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule